// File: doc/BRIEF.md
# Split-Permission Translation Buffer with Walker Refill

This block is a direct-mapped virtual-to-physical translation buffer. It keeps a separate tag array for each access kind (load, store and instruction fetch), all indexed by the same set index, and a single shared array that holds the physical page number of each entry. A request is looked up against the tag array of its own kind. The hit or miss result and the physical address come out one cycle later.

On a miss the block holds the request and raises a walk request to an external page-table walker. The walk request carries the virtual address and a flag that says whether the miss came from a store. When the walker signals done, each tag array is written with the valid tag only if the returned permission allows that kind of access. The store array also needs the miss itself to have been a store. A page that was filled by a load or fetch therefore misses on its first store and goes back to the walker, which can then mark the page dirty. A faulting walk writes nothing and raises a fault pulse. A flush input invalidates all entries of all three arrays in one cycle.

Top module: `tlb_split_refill`

## Requirements
- R1: After reset every entry is invalid in all three arrays, so the first access of any kind misses. `busy`, `rsp_valid`, `walk_req` and `fault_valid` are low.
- R2: A request accepted while `busy` is low gives `rsp_valid` on the next cycle, with `rsp_type` echoing `req_type` (00 load, 01 store, 10 fetch). On a hit, `rsp_paddr` = {stored page number, `req_vaddr[11:0]`}.
- R3: A miss raises `walk_req` and `busy` in the cycle after the request. `walk_vaddr` equals the missing address and `walk_store` is 1 exactly when the miss was a store (type 01). All three hold steady until the cycle in which `walk_done` is seen, after which they drop.
- R4: After a refill, a load to that page hits only if the read permission bit `walk_perm[0]` was 1. Otherwise it misses.
- R5: After a refill, a fetch to that page hits only if the execute permission bit `walk_perm[2]` was 1. Otherwise it misses.
- R6: A refill caused by a load or fetch leaves the store array invalid even when the write permission `walk_perm[1]` is 1. A later store misses and walks with `walk_store` = 1.
- R7: A refill caused by a store with `walk_perm[1]` = 1 makes later stores to the page hit. The load and fetch arrays follow their own permission bits in the same refill.
- R8: A walk that ends with `walk_fault` = 1 writes no tag. `fault_valid` pulses for one cycle in the cycle after `walk_done`, and `fault_type` holds the missing access kind.
- R9: A one-cycle `flush` pulse invalidates every entry. Any request issued after it misses.
- R10: When `flush` and a successful `walk_done` fall in the same cycle, the flush wins and no tag is written.
- R11: The buffer is direct-mapped on `vaddr[17:12]`, with the tag taken from `vaddr[31:18]`. A refill for a page with the same index and a different tag evicts the old page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the request |
| req_type | input | 2 | 00 load, 01 store, 10 fetch |
| busy | output | 1 | Walk in progress; requests are not accepted |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_type | output | 2 | Access kind of the result |
| rsp_paddr | output | 34 | Physical address on a hit, zero on a miss |
| walk_req | output | 1 | Walk request, held until done |
| walk_vaddr | output | 32 | Address to walk |
| walk_store | output | 1 | The miss came from a store |
| walk_done | input | 1 | Walker finished |
| walk_fault | input | 1 | Walker found no legal mapping |
| walk_ppn | input | 22 | Physical page number of the leaf |
| walk_perm | input | 3 | Bit 0 read, bit 1 write, bit 2 execute |
| fault_valid | output | 1 | Walk fault pulse |
| fault_type | output | 2 | Access kind of the faulting miss |

## Verification
Flush and refill can land in the same cycle: a walk is finishing while software invalidates the buffer. The bench provokes this by driving `flush` in the same cycle as a successful `walk_done`. It then judges the outcome by re-issuing the same load and expecting a miss followed by a new walk, not a hit. A flush that arrives a cycle apart from the refill is also checked, and another request after it must miss.

// File: rtl/tlb_split_refill.sv
module tlb_split_refill #(
  parameter int ENTRIES   = 64,
  parameter int PAGE_BITS = 12,
  parameter int VA_W      = 32,
  parameter int PA_W      = 34
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_type,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [1:0]                rsp_type,
  output logic [PA_W-1:0]           rsp_paddr,
  output logic                      walk_req,
  output logic [VA_W-1:0]           walk_vaddr,
  output logic                      walk_store,
  input  logic                      walk_done,
  input  logic                      walk_fault,
  input  logic [PA_W-PAGE_BITS-1:0] walk_ppn,
  input  logic [2:0]                walk_perm,
  output logic                      fault_valid,
  output logic [1:0]                fault_type
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam logic [TAG_W:0] NO_TAG = '1;

  logic [TAG_W:0]   ld_tag [ENTRIES];
  logic [TAG_W:0]   st_tag [ENTRIES];
  logic [TAG_W:0]   fx_tag [ENTRIES];
  logic [PPN_W-1:0] ppn_mem [ENTRIES];

  logic [IDX_W-1:0] idx, ridx;
  logic [TAG_W:0]   key, rkey, sel;
  logic             hit, accept, refill;
  logic [VA_W-1:0]  pend_va;
  logic [1:0]       pend_type;

  assign idx    = req_vaddr[PAGE_BITS +: IDX_W];
  assign key    = {1'b0, req_vaddr[VA_W-1 -: TAG_W]};
  assign ridx   = pend_va[PAGE_BITS +: IDX_W];
  assign rkey   = {1'b0, pend_va[VA_W-1 -: TAG_W]};
  assign accept = req_valid && !busy;
  assign refill = busy && walk_done && !walk_fault && !flush;

  always_comb begin
    case (req_type)
      2'b00:   sel = ld_tag[idx];
      2'b01:   sel = st_tag[idx];
      default: sel = fx_tag[idx];
    endcase
  end
  assign hit = (sel == key);

  assign walk_req   = busy;
  assign walk_vaddr = pend_va;
  assign walk_store = (pend_type == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ld_tag[i] <= NO_TAG;
        st_tag[i] <= NO_TAG;
        fx_tag[i] <= NO_TAG;
      end
    end else if (refill) begin
      ld_tag[ridx] <= walk_perm[0] ? rkey : NO_TAG;
      st_tag[ridx] <= (walk_perm[1] && pend_type == 2'b01) ? rkey : NO_TAG;
      fx_tag[ridx] <= walk_perm[2] ? rkey : NO_TAG;
    end
  end

  always_ff @(posedge clk) begin
    if (refill) ppn_mem[ridx] <= walk_ppn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_type    <= 2'b00;
      rsp_paddr   <= '0;
      pend_va     <= '0;
      pend_type   <= 2'b00;
      fault_valid <= 1'b0;
      fault_type  <= 2'b00;
    end else begin
      rsp_valid   <= accept;
      fault_valid <= busy && walk_done && walk_fault;
      fault_type  <= pend_type;
      if (accept) begin
        rsp_hit   <= hit;
        rsp_type  <= req_type;
        rsp_paddr <= hit ? {ppn_mem[idx], req_vaddr[PAGE_BITS-1:0]} : '0;
        if (!hit) begin
          busy      <= 1'b1;
          pend_va   <= req_vaddr;
          pend_type <= req_type;
        end
      end else if (busy && walk_done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

module tlb_split_refill_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            walk_req,
  input logic [VA_W-1:0] walk_vaddr,
  input logic            walk_done,
  input logic            walk_fault,
  input logic            fault_valid
);
  // R2
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !busy));
  // R3
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req) |-> (rsp_valid && !rsp_hit));
  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_vaddr)));
  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(walk_req && walk_done && walk_fault));
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && rsp_valid |-> !$past(flush, 2));
endmodule

bind tlb_split_refill tlb_split_refill_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_done(walk_done),
  .walk_fault(walk_fault), .fault_valid(fault_valid)
);

// File: tb/tb_tlb_split_refill.sv
module tb_tlb_split_refill;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid, walk_done, walk_fault;
  logic [31:0] req_vaddr;
  logic [1:0]  req_type;
  logic [21:0] walk_ppn;
  logic [2:0]  walk_perm;
  logic        busy, rsp_valid, rsp_hit, walk_req, walk_store, fault_valid;
  logic [1:0]  rsp_type, fault_type;
  logic [33:0] rsp_paddr;
  logic [31:0] walk_vaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_split_refill dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_type(req_type), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_type(rsp_type),
    .rsp_paddr(rsp_paddr), .walk_req(walk_req), .walk_vaddr(walk_vaddr),
    .walk_store(walk_store), .walk_done(walk_done), .walk_fault(walk_fault),
    .walk_ppn(walk_ppn), .walk_perm(walk_perm), .fault_valid(fault_valid),
    .fault_type(fault_type)
  );

  typedef struct {
    logic        hit;
    logic [33:0] pa;
    logic [1:0]  ty;
    string       rq;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 1'b0;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, FX = 2'b10;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [33:0] pa(logic [21:0] ppn, logic [31:0] va);
    return {ppn, va[11:0]};
  endfunction

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk("R2 unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.rq, " hit"}, 64'(rsp_hit), 64'(e.hit));
        chk({e.rq, " type"}, 64'(rsp_type), 64'(e.ty));
        if (e.hit) chk({e.rq, " paddr"}, 64'(rsp_paddr), 64'(e.pa));
      end
    end
  end

  task automatic access(logic [31:0] va, logic [1:0] ty, logic h, logic [33:0] p, string rq);
    exp_t e;
    e.hit = h; e.pa = p; e.ty = ty; e.rq = rq;
    q.push_back(e);
    req_valid = 1'b1; req_vaddr = va; req_type = ty;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk(logic [31:0] va, logic st, logic [21:0] ppn, logic [2:0] perm,
                      logic flt, logic [1:0] fty, int dly, logic with_flush, string rq);
    chk({rq, " R3 walk_req"}, 64'(walk_req), 64'd1);
    chk({rq, " R3 busy"}, 64'(busy), 64'd1);
    chk({rq, " R3 walk_vaddr"}, 64'(walk_vaddr), 64'(va));
    chk({rq, " R3 walk_store"}, 64'(walk_store), 64'(st));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk({rq, " R3 walk held"}, 64'({walk_req, walk_store}), 64'({1'b1, st}));
    end
    walk_done = 1'b1; walk_fault = flt; walk_ppn = ppn; walk_perm = perm;
    flush = with_flush;
    @(negedge clk);
    walk_done = 1'b0; walk_fault = 1'b0; flush = 1'b0;
    chk({rq, " R3 walk dropped"}, 64'(walk_req), 64'd0);
    chk({rq, " R8 fault_valid"}, 64'(fault_valid), 64'(flt));
    if (flt) chk({rq, " R8 fault_type"}, 64'(fault_type), 64'(fty));
    @(negedge clk);
    chk({rq, " R8 fault pulse one cycle"}, 64'(fault_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    logic [31:0] A, B, C;
    A = 32'h0004_5123;   // index 5, tag 1
    B = 32'h0008_5040;   // index 5, tag 2
    C = 32'h0000_3ABC;   // index 3, tag 0
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_type = LD;
    walk_done = 1'b0; walk_fault = 1'b0; walk_ppn = '0; walk_perm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 walk_req", 64'(walk_req), 64'd0);
    chk("R1 fault_valid", 64'(fault_valid), 64'd0);

    // R1 first access misses; R4 load refill with read+write
    access(A, LD, 1'b0, '0, "R1 cold load");
    walk(A, 1'b0, 22'h12345, 3'b011, 1'b0, LD, 2, 1'b0, "R1");
    access(A, LD, 1'b1, pa(22'h12345, A), "R4 R2 load hit");
    // R6 load refill left store tag invalid
    access(A, ST, 1'b0, '0, "R6 first store misses");
    walk(A, 1'b1, 22'h12345, 3'b011, 1'b0, ST, 0, 1'b0, "R6");
    access(A, ST, 1'b1, pa(22'h12345, A), "R7 store hit");
    access(A, LD, 1'b1, pa(22'h12345, A), "R7 load hit");
    // R5 no execute permission yet
    access(A, FX, 1'b0, '0, "R5 fetch misses");
    walk(A, 1'b0, 22'h00ABC, 3'b100, 1'b0, FX, 1, 1'b0, "R5");
    access(A + 32'h10, FX, 1'b1, pa(22'h00ABC, A + 32'h10), "R5 fetch hit");
    access(A, LD, 1'b0, '0, "R4 load misses without read");
    walk(A, 1'b0, 22'h0, 3'b000, 1'b1, LD, 0, 1'b0, "R8 fault");
    access(A, LD, 1'b0, '0, "R8 no tag written");
    walk(A, 1'b0, 22'h00055, 3'b001, 1'b0, LD, 0, 1'b0, "R4");
    access(A, LD, 1'b1, pa(22'h00055, A), "R4 load hit after refill");
    access(A, FX, 1'b0, '0, "R5 fetch misses after read-only refill");
    walk(A, 1'b0, 22'h00077, 3'b111, 1'b0, FX, 0, 1'b0, "R5");
    access(A, ST, 1'b0, '0, "R6 fetch refill leaves store invalid");
    walk(A, 1'b1, 22'h00077, 3'b111, 1'b0, ST, 0, 1'b0, "R6");
    access(A, LD, 1'b1, pa(22'h00077, A), "R7 load");
    access(A, ST, 1'b1, pa(22'h00077, A), "R7 store");
    access(A, FX, 1'b1, pa(22'h00077, A), "R7 fetch");

    // R11 same index, other tag
    access(B, LD, 1'b0, '0, "R11 other tag misses");
    walk(B, 1'b0, 22'h00099, 3'b001, 1'b0, LD, 0, 1'b0, "R11");
    access(B, LD, 1'b1, pa(22'h00099, B), "R11 new page hits");
    access(A, LD, 1'b0, '0, "R11 old page evicted");
    walk(A, 1'b0, 22'h0, 3'b000, 1'b1, LD, 0, 1'b0, "R11 fault");
    access(A, ST, 1'b0, '0, "R11 store array evicted");
    walk(A, 1'b1, 22'h0, 3'b000, 1'b1, ST, 0, 1'b0, "R8 store fault");

    // R9 flush
    access(C, LD, 1'b0, '0, "R9 cold");
    walk(C, 1'b0, 22'h00003, 3'b011, 1'b0, LD, 0, 1'b0, "R9");
    access(C, LD, 1'b1, pa(22'h00003, C), "R9 hit before flush");
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    access(C, LD, 1'b0, '0, "R9 miss after flush");
    // R10 flush together with done
    walk(C, 1'b0, 22'h00003, 3'b001, 1'b0, LD, 0, 1'b1, "R10");
    access(C, LD, 1'b0, '0, "R10 flush beat refill");
    walk(C, 1'b0, 22'h00004, 3'b001, 1'b0, LD, 0, 1'b0, "R10");
    access(C, LD, 1'b1, pa(22'h00004, C), "R10 refill after");
    access(B, LD, 1'b0, '0, "R9 other entry flushed");
    walk(B, 1'b0, 22'h0, 3'b000, 1'b1, LD, 0, 1'b0, "R9 fault");

    repeat (2) @(negedge clk);
    chk("R2 all responses seen", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule